// File: doc/BRIEF.md
# Masked priority interrupt aggregator

This block gathers thirteen peripheral interrupt lines into one 32-bit pending-status word. Each line owns a fixed bit of that word and belongs to one of three processor priority levels: 3, 5 or 6. A 32-bit enable mask sits beside the status word. Both registers sit on a small register bus at two fixed offsets, and a 32-bit write replaces either register whole. Status is written directly, not through write-one-to-clear.

Each line is edge-sensitive. A rising edge sets the line's status bit and a falling edge clears it. Between edges, software owns the bit. A separate disk-DMA enable control also drives the disk-DMA status bit. The block drives a 3-bit level to the processor. That level is the highest priority among bits that are both pending and enabled, or zero when none are.

Top module: `irq_prio_aggregator`

## Requirements
- R1: After reset, status and mask both read 0 and `irq_level` is 0.
- R2: A write with `bus_addr` = 0x7800 replaces all 32 mask bits, and a read at 0x7800 returns the mask. A mask bit of 1 enables that bit.
- R3: A write with `bus_addr` = 0x7000 replaces all 32 status bits, including bits that no line owns, and a read at 0x7000 returns the status.
- R4: A rising edge on `src_irq[i]` sets its status bit after the next clock edge. The bit and level for each index are: 0→bit 7 (L3), 1→3 (L3), 2→2 (L3), 3→9 (L3), 4→10 (L3), 5→12 (L3), 6→5 (L3), 7→17 (L5), 8→28 (L6), 9→27 (L6), 10→26 (L6), 11→21 (L6), 12→23 (L6).
- R5: A falling edge on `src_irq[i]` clears its status bit. A line held steady does not touch its bit, so a bit cleared by software while its line stays high stays clear.
- R6: `irq_level` is the largest level among lines whose status bit and mask bit are both 1, and 0 when there is no such line. Status bits that no line owns never raise the level.
- R7: When a line edge and a status write fall in the same cycle, the line's bit follows the edge. Every other bit takes the written value.
- R8: A rising edge on `dma_ctl_en` sets status bit 26 and a falling edge clears it. This edge wins over a same-cycle edge on the disk-DMA line and over a same-cycle status write.
- R9: Writes to any offset other than 0x7000 and 0x7800 change nothing, and reads of those offsets return 0.
- R10: `bus_rdata` follows `bus_addr` combinationally. `irq_level` follows the registers with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 13 | Peripheral interrupt lines, indexed as in R4 |
| dma_ctl_en | input | 1 | Disk-DMA enable control |
| bus_addr | input | 16 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq_level | output | 3 | Encoded processor priority level |

## Verification
A wrong bit position or a lost edge shows up at the next clock edge in two places: a readback at 0x7000 that differs from the expected word, and a wrong value on `irq_level`. A wrong ordering between events and writes shows up only in the cycle where both happen, so those cycles are driven on purpose. A stale or wrong mask shows up only as a wrong level. For that reason the level is checked against an arithmetic model for every one of the 8192 combinations of line bits, under three mask patterns.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned IRQ_SRC_COUNT = 13;
   localparam int unsigned IRQ_POS_W     = 5;
   localparam int unsigned IRQ_LVL_W     = 3;

   typedef logic [IRQ_LVL_W-1:0] irq_lvl_t;

   // index 0 sits in the least significant slot
   localparam logic [IRQ_SRC_COUNT*IRQ_POS_W-1:0] IRQ_DEFAULT_POS = {
      5'd23, 5'd21, 5'd26, 5'd27, 5'd28,
      5'd17,
      5'd5, 5'd12, 5'd10, 5'd9, 5'd2, 5'd3, 5'd7 };

   localparam logic [IRQ_SRC_COUNT*IRQ_LVL_W-1:0] IRQ_DEFAULT_LVL = {
      3'd6, 3'd6, 3'd6, 3'd6, 3'd6,
      3'd5,
      3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3 };
endpackage

// File: rtl/irq_edge_sense.sv
module irq_edge_sense #(
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] line_in,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   initial begin
      if (WIDTH < 1) $error("irq_edge_sense: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] prev_q;

   genvar g;
   generate
      for (g = 0; g < int'(WIDTH); g++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= line_in[g];
         end
         assign rise_o[g] =  line_in[g] & ~prev_q[g];
         assign fall_o[g] = ~line_in[g] &  prev_q[g];
      end
   endgenerate
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned N_SRC       = 13,
   parameter int unsigned POS_W       = 5,
   parameter logic [N_SRC*POS_W-1:0] SRC_POS = '0,
   parameter bit          CTRL_ENABLE = 1'b1,
   parameter int unsigned CTRL_BIT    = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N_SRC-1:0]  src_rise,
   input  logic [N_SRC-1:0]  src_fall,
   input  logic              ctrl_rise,
   input  logic              ctrl_fall,
   output logic [DATA_W-1:0] status_q
);
   logic [DATA_W-1:0] status_d;

   always_comb begin
      status_d = status_q;
      if (wr_en) status_d = wdata;
      for (int i = 0; i < int'(N_SRC); i++) begin
         if (src_rise[i])      status_d[SRC_POS[i*POS_W +: POS_W]] = 1'b1;
         else if (src_fall[i]) status_d[SRC_POS[i*POS_W +: POS_W]] = 1'b0;
      end
      if (CTRL_ENABLE) begin
         if (ctrl_rise)      status_d[CTRL_BIT] = 1'b1;
         else if (ctrl_fall) status_d[CTRL_BIT] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end

   // line edges against the stored bit; R7 is covered by the same-cycle write case
   genvar g;
   generate
      for (g = 0; g < int'(N_SRC); g++) begin : g_chk
         if (!(CTRL_ENABLE && (int'(SRC_POS[g*POS_W +: POS_W]) == int'(CTRL_BIT)))) begin : g_free
            assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
               src_rise[g] |=> status_q[SRC_POS[g*POS_W +: POS_W]]);
            assert_fall_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
               src_fall[g] |=> !status_q[SRC_POS[g*POS_W +: POS_W]]);
         end
      end
      if (CTRL_ENABLE) begin : g_ctrl_chk
         assert_ctrl_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_rise |=> status_q[CTRL_BIT]);
         assert_ctrl_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_fall |=> !status_q[CTRL_BIT]);
      end
   endgenerate

   assert_status_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (src_rise == '0) && (src_fall == '0) && !ctrl_rise && !ctrl_fall)
      |=> status_q == $past(wdata));
endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_SRC  = 13,
   parameter int unsigned POS_W  = 5,
   parameter int unsigned LVL_W  = 3,
   parameter logic [N_SRC*POS_W-1:0] SRC_POS   = '0,
   parameter logic [N_SRC*LVL_W-1:0] SRC_LEVEL = '0
) (
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic [LVL_W-1:0]  level_o
);
   logic [N_SRC-1:0] live;

   genvar g;
   generate
      for (g = 0; g < int'(N_SRC); g++) begin : g_live
         assign live[g] = status_i[SRC_POS[g*POS_W +: POS_W]] &
                          mask_i[SRC_POS[g*POS_W +: POS_W]];
      end
   endgenerate

   always_comb begin
      level_o = '0;
      for (int i = 0; i < int'(N_SRC); i++) begin
         if (live[i] && (SRC_LEVEL[i*LVL_W +: LVL_W] > level_o))
            level_o = SRC_LEVEL[i*LVL_W +: LVL_W];
      end
   end
endmodule

// File: rtl/irq_prio_aggregator.sv
module irq_prio_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned N_SRC       = IRQ_SRC_COUNT,
   parameter int unsigned POS_W       = IRQ_POS_W,
   parameter int unsigned LVL_W       = IRQ_LVL_W,
   parameter logic [N_SRC*POS_W-1:0] SRC_POS   = IRQ_DEFAULT_POS,
   parameter logic [N_SRC*LVL_W-1:0] SRC_LEVEL = IRQ_DEFAULT_LVL,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
   parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800,
   parameter bit          CTRL_ENABLE = 1'b1,
   parameter int unsigned CTRL_BIT    = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_irq,
   input  logic              dma_ctl_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [LVL_W-1:0]  irq_level
);
   function automatic logic [DATA_W-1:0] owned_bits();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < int'(N_SRC); i++) m[SRC_POS[i*POS_W +: POS_W]] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] OWNED = owned_bits();

   // elaboration-time parameter checks
   initial begin
      if ((1 << POS_W) < DATA_W) $error("POS_W too narrow for DATA_W");
      if (STATUS_OFS == MASK_OFS) $error("status and mask offsets collide");
      if (CTRL_ENABLE && (CTRL_BIT >= DATA_W)) $error("CTRL_BIT out of range");
   end

   genvar gi, gj;
   generate
      for (gi = 0; gi < int'(N_SRC); gi++) begin : g_pchk
         if (int'(SRC_POS[gi*POS_W +: POS_W]) >= int'(DATA_W)) begin : g_range
            initial $error("source bit position out of range");
         end
         if (SRC_LEVEL[gi*LVL_W +: LVL_W] == '0) begin : g_zero
            initial $error("source level must be nonzero");
         end
         for (gj = gi + 1; gj < int'(N_SRC); gj++) begin : g_dup
            if (SRC_POS[gi*POS_W +: POS_W] == SRC_POS[gj*POS_W +: POS_W]) begin : g_hit
               initial $error("two sources share a status bit");
            end
         end
      end
   endgenerate

   logic              hit_status;
   logic              hit_mask;
   logic [N_SRC-1:0]  src_rise;
   logic [N_SRC-1:0]  src_fall;
   logic              ctrl_rise;
   logic              ctrl_fall;
   logic [DATA_W-1:0] status_q;
   logic [DATA_W-1:0] mask_q;

   assign hit_status = (bus_addr == STATUS_OFS);
   assign hit_mask   = (bus_addr == MASK_OFS);

   irq_edge_sense #(.WIDTH(N_SRC)) u_src_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (src_irq),
      .rise_o  (src_rise),
      .fall_o  (src_fall)
   );

   generate
      if (CTRL_ENABLE) begin : g_ctrl
         irq_edge_sense #(.WIDTH(1)) u_ctrl_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (dma_ctl_en),
            .rise_o  (ctrl_rise),
            .fall_o  (ctrl_fall)
         );
      end else begin : g_no_ctrl
         assign ctrl_rise = 1'b0;
         assign ctrl_fall = 1'b0;
      end
   endgenerate

   irq_status_bank #(
      .DATA_W      (DATA_W),
      .N_SRC       (N_SRC),
      .POS_W       (POS_W),
      .SRC_POS     (SRC_POS),
      .CTRL_ENABLE (CTRL_ENABLE),
      .CTRL_BIT    (CTRL_BIT)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr & hit_status),
      .wdata     (bus_wdata),
      .src_rise  (src_rise),
      .src_fall  (src_fall),
      .ctrl_rise (ctrl_rise),
      .ctrl_fall (ctrl_fall),
      .status_q  (status_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mask_q <= '0;
      else if (bus_wr && hit_mask) mask_q <= bus_wdata;
   end

   always_comb begin
      if (hit_status)    bus_rdata = status_q;
      else if (hit_mask) bus_rdata = mask_q;
      else               bus_rdata = '0;
   end

   irq_level_encoder #(
      .DATA_W    (DATA_W),
      .N_SRC     (N_SRC),
      .POS_W     (POS_W),
      .LVL_W     (LVL_W),
      .SRC_POS   (SRC_POS),
      .SRC_LEVEL (SRC_LEVEL)
   ) u_enc (
      .status_i (status_q),
      .mask_i   (mask_q),
      .level_o  (irq_level)
   );

   assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_mask) |=> mask_q == $past(bus_wdata));

   assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && hit_mask) |=> $stable(mask_q));

   assert_level_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & mask_q & OWNED) == '0) |-> (irq_level == '0));

   assert_level_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != '0) |-> ((status_q & mask_q & OWNED) != '0));
endmodule

// File: tb/test_irq_prio_aggregator.sv
module test_irq_prio_aggregator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] src_irq = '0;
   logic        dma_ctl_en = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq_level;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   irq_prio_aggregator i_irq_prio_aggregator (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_irq    (src_irq),
      .dma_ctl_en (dma_ctl_en),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq_level  (irq_level)
   );

   // line table from R4
   function automatic int pos_of(int i);
      int p[13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 21, 23};
      return p[i];
   endfunction
   function automatic int lvl_of(int i);
      if (i < 7)  return 3;
      if (i == 7) return 5;
      return 6;
   endfunction
   function automatic logic [2:0] exp_level(logic [31:0] st, logic [31:0] mk);
      int best = 0;
      for (int i = 0; i < 13; i++)
         if (st[pos_of(i)] && mk[pos_of(i)] && lvl_of(i) > best) best = lvl_of(i);
      return 3'(best);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [15:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #2;
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [15:0] a, output logic [31:0] d);
      bus_addr = a; #1;
      d = bus_rdata;
      @(posedge clk); #2;
   endtask

   task automatic drive_src(logic [12:0] v);
      src_irq = v;
      @(posedge clk); #2;
   endtask

   initial begin
      logic [31:0] rd;
      logic [31:0] mk;
      logic [31:0] st;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      check("R1 level", {29'd0, irq_level}, 32'd0);
      bus_read(16'h7000, rd); check("R1 status", rd, 32'd0);
      bus_read(16'h7800, rd); check("R1 mask", rd, 32'd0);

      // R2 mask write and readback
      foreach (st[k]) begin end
      for (int k = 0; k < 4; k++) begin
         mk = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'hA5A5_5A5A :
              (k == 2) ? 32'h0000_0001 : 32'h8000_0000;
         bus_write(16'h7800, mk);
         bus_read(16'h7800, rd); check("R2 mask readback", rd, mk);
      end

      // R3 status write incl. unowned bits, R10 combinational read
      bus_write(16'h7800, 32'h0);
      for (int k = 0; k < 3; k++) begin
         st = (k == 0) ? 32'hDEAD_BEEF : (k == 1) ? 32'h0001_0001 : 32'h0;
         bus_write(16'h7000, st);
         bus_read(16'h7000, rd); check("R3 status readback", rd, st);
         check("R6 masked level", {29'd0, irq_level}, 32'd0);
      end

      // R4/R5 per-line sweep with all bits enabled
      bus_write(16'h7800, 32'hFFFF_FFFF);
      for (int i = 0; i < 13; i++) begin
         drive_src(13'(1) << i);
         check("R10 level after rise", {29'd0, irq_level}, 32'(lvl_of(i)));
         bus_read(16'h7000, rd); check("R4 rise sets bit", rd, 32'(1) << pos_of(i));
         drive_src('0);
         check("R6 level idle", {29'd0, irq_level}, 32'd0);
         bus_read(16'h7000, rd); check("R5 fall clears bit", rd, 32'd0);
      end

      // R5 steady line leaves a software-cleared bit clear
      drive_src(13'h0001);
      bus_write(16'h7000, 32'h0);
      repeat (3) @(posedge clk); #2;
      bus_read(16'h7000, rd); check("R5 held line no effect", rd, 32'd0);
      check("R5 level", {29'd0, irq_level}, 32'd0);
      drive_src('0);

      // R7 edge wins over a same-cycle write
      src_irq = 13'h0080;                      // serial line rise, bit 17
      bus_write(16'h7000, 32'h0000_0400);
      bus_read(16'h7000, rd); check("R7 rise vs write", rd, 32'h0002_0400);
      src_irq = 13'h0000;                      // serial line fall
      bus_write(16'h7000, 32'hFFFF_FFFF);
      bus_read(16'h7000, rd); check("R7 fall vs write", rd, 32'hFFFD_FFFF);
      bus_write(16'h7000, 32'h0);

      // R8 control edges and conflicts
      dma_ctl_en = 1'b1; @(posedge clk); #2;
      bus_read(16'h7000, rd); check("R8 ctrl rise", rd, 32'h0400_0000);
      check("R8 level", {29'd0, irq_level}, 32'd6);
      dma_ctl_en = 1'b0; @(posedge clk); #2;
      bus_read(16'h7000, rd); check("R8 ctrl fall", rd, 32'd0);
      drive_src(13'h0400);                     // disk-DMA line high
      bus_write(16'h7000, 32'h0);
      dma_ctl_en = 1'b1; src_irq = 13'h0000;   // ctrl rise vs line fall
      @(posedge clk); #2;
      bus_read(16'h7000, rd); check("R8 ctrl rise beats line fall", rd, 32'h0400_0000);
      dma_ctl_en = 1'b0; src_irq = 13'h0400;   // ctrl fall vs line rise
      @(posedge clk); #2;
      bus_read(16'h7000, rd); check("R8 ctrl fall beats line rise", rd, 32'd0);
      dma_ctl_en = 1'b1;
      bus_write(16'h7000, 32'h0);              // ctrl rise vs write 0
      bus_read(16'h7000, rd); check("R8 ctrl beats write", rd, 32'h0400_0000);
      dma_ctl_en = 1'b0; drive_src('0);
      bus_write(16'h7000, 32'h0);

      // R9 other offsets
      bus_write(16'h7000, 32'h1234_5678);
      bus_write(16'h7800, 32'h0F0F_0F0F);
      bus_write(16'h7004, 32'hFFFF_FFFF);
      bus_write(16'h0000, 32'hFFFF_FFFF);
      bus_write(16'hF800, 32'h0);
      bus_read(16'h7000, rd); check("R9 status untouched", rd, 32'h1234_5678);
      bus_read(16'h7800, rd); check("R9 mask untouched", rd, 32'h0F0F_0F0F);
      bus_read(16'h7004, rd); check("R9 stray read", rd, 32'd0);
      bus_read(16'h3000, rd); check("R9 stray read", rd, 32'd0);

      // R6 exhaustive level sweep over every line-bit combination
      for (int pass = 0; pass < 3; pass++) begin
         mk = (pass == 0) ? 32'hFFFF_FFFF : (pass == 1) ? 32'hE3FF_FFFF & ~32'h00A0_0000
                                                       : 32'h1C22_0288;
         bus_write(16'h7800, mk);
         for (int s = 0; s < 8192; s++) begin
            st = 32'h4001_0001;               // unowned bits always set
            for (int i = 0; i < 13; i++) if (s[i]) st[pos_of(i)] = 1'b1;
            bus_write(16'h7000, st);
            check("R6 level sweep", {29'd0, irq_level}, {29'd0, exp_level(st, mk)});
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      #(150000 * 10);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule